// File: doc/BRIEF.md
# Banked Multi-Lane Scratchpad

This block is a 16 KB scratchpad that sixteen parallel lanes reach in a single request. A request carries one word address per lane, an active mask and, for a store, one 32-bit word per lane. The storage is spread over sixteen single-ported banks of 256 words each. Word addresses are interleaved, so the low four bits pick the bank and the upper eight bits pick the row.

Each bank serves one address per cycle. When active lanes reach different words in the same bank, those accesses are serialized over several service cycles. Lanes that name the very same word share one access, which works as a broadcast. So a request with no conflicts finishes in a single service cycle. A request with conflicts takes as many cycles as the busiest bank has distinct addresses.

The ready output is low while a request is being worked off. Load results for all lanes appear together, with a per-lane valid, in the cycle after the last service cycle.

Top module: `scp_banked_top`

## Requirements
- R1: After reset, `req_ready` is 1 and `rd_valid` is all zero.
- R2: Word address A is held in bank A mod 16 at row A div 16. A load of A returns the last word stored at A.
- R3: A request whose active lanes all fall in different banks takes exactly one service cycle.
- R4: Active lanes that load the same word address share one access. Every one of them receives that word, and together they add only one to their bank's count.
- R5: A request takes as many service cycles as the largest number of distinct word addresses that active lanes aim at one bank. A request with no active lane takes one cycle.
- R6: When several active lanes store to the same word in one request, the word from the highest-numbered of those lanes is kept.
- R7: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is then 0 from the next cycle through the final service cycle, and 1 again in the cycle after it.
- R8: In the cycle after the final service cycle, `rd_valid` pulses for one cycle. For a load it equals the active mask, and for a store it stays zero. `rd_data` lane k (bits 32k+31..32k) carries lane k's word.
- R9: Inactive lanes store nothing, add nothing to any bank's count and get no valid, whatever their address and data.
- R10: Conflicts are counted within one request only. Back-to-back requests each take their own count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_active | input | 16 | Per-lane active mask |
| req_addr | input | 192 | Lane k word address in bits 12k+11..12k |
| req_wdata | input | 512 | Lane k store word in bits 32k+31..32k |
| req_ready | output | 1 | Idle and able to accept a request |
| rd_valid | output | 16 | Per-lane load result valid, one-cycle pulse |
| rd_data | output | 512 | Lane k load word in bits 32k+31..32k |

## Verification
The bench targets several corner cases:
- A stride of 16 puts every lane on one bank and must take sixteen cycles. A design that ignored the bank index would take one.
- A stride of 2 must take two cycles. A wrong bank decode or row decode shows up as a wrong cycle count or as data from the wrong word.
- A broadcast to one address must finish in one cycle. A design that serialized identical addresses would take sixteen.
- All lanes storing to one word must keep lane 15's data. Priority to the lowest lane would keep lane 0's instead.
- Inactive lanes are given addresses that would conflict and data that would overwrite. A design that looked at them would show extra cycles or corrupted words on later loads.

// File: rtl/scp_pkg.sv
package scp_pkg;
    localparam int unsigned LANES  = 16;
    localparam int unsigned BANKS  = 16;
    localparam int unsigned ROWS   = 256;
    localparam int unsigned DW     = 32;
    localparam int unsigned BANK_W = $clog2(BANKS);
    localparam int unsigned ROW_W  = $clog2(ROWS);
    localparam int unsigned AW     = BANK_W + ROW_W;
    localparam int unsigned LANE_W = $clog2(LANES);

    typedef logic [AW-1:0]     addr_t;
    typedef logic [DW-1:0]     word_t;
    typedef logic [BANK_W-1:0] bank_t;
    typedef logic [ROW_W-1:0]  row_t;
    typedef logic [LANES-1:0]  lmask_t;

    typedef enum logic {ST_IDLE, ST_SERVE} state_t;

    typedef struct packed {
        logic   write;
        lmask_t active;
    } req_hdr_t;

    function automatic bank_t bank_of(input addr_t a);
        return a[BANK_W-1:0];
    endfunction

    function automatic row_t row_of(input addr_t a);
        return a[AW-1:BANK_W];
    endfunction
endpackage

// File: rtl/scp_bank.sv
module scp_bank
    import scp_pkg::*;
(
    input  logic  clk,
    input  logic  wr_en,
    input  row_t  row,
    input  word_t wdata,
    output word_t rdata
);
    word_t mem [ROWS];

    always_ff @(posedge clk) begin
        if (wr_en) mem[row] <= wdata;
    end

    assign rdata = mem[row];
endmodule

// File: rtl/scp_bank_pick.sv
module scp_bank_pick
    import scp_pkg::*;
#(
    parameter int unsigned BANK_ID = 0
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   enable,
    input  lmask_t pending,
    input  addr_t  addr  [LANES],
    input  word_t  wdata [LANES],
    output lmask_t served,
    output logic   hit_any,
    output row_t   row,
    output word_t  wsel
);
    lmask_t hit;
    addr_t  sel;

    // lowest pending lane on this bank picks the address; equal addresses ride along
    always_comb begin
        hit     = '0;
        hit_any = 1'b0;
        sel     = '0;
        for (int l = 0; l < LANES; l++) begin
            hit[l] = enable && pending[l] && (bank_of(addr[l]) == bank_t'(BANK_ID));
            if (hit[l] && !hit_any) begin
                hit_any = 1'b1;
                sel     = addr[l];
            end
        end
        served = '0;
        wsel   = '0;
        for (int l = 0; l < LANES; l++) begin
            served[l] = hit[l] && (addr[l] == sel);
            if (served[l]) wsel = wdata[l];   // ascending order: highest lane wins
        end
        row = row_of(sel);
    end

    // R5: a bank with pending work always makes progress this cycle
    a_r5_bank_progress: assert property (@(posedge clk) disable iff (rst)
        hit_any |-> (served != '0));
endmodule

// File: rtl/scp_banked_top.sv
module scp_banked_top
    import scp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [LANES-1:0]      req_active,
    input  logic [LANES*AW-1:0]   req_addr,
    input  logic [LANES*DW-1:0]   req_wdata,
    output logic                  req_ready,
    output logic [LANES-1:0]      rd_valid,
    output logic [LANES*DW-1:0]   rd_data
);
    localparam logic [LANE_W:0] SVC_LIM = (LANE_W+1)'(LANES);

    state_t   st;
    req_hdr_t hdr_q;
    lmask_t   pend_q, pend_nxt, served_all;
    addr_t    addr_q [LANES];
    word_t    wd_q   [LANES];
    word_t    res_q  [LANES];
    lmask_t   rdv_q;
    logic [LANE_W:0] svc_cnt;

    lmask_t   served_b [BANKS];
    logic     any_b    [BANKS];
    row_t     row_b    [BANKS];
    word_t    wsel_b   [BANKS];
    word_t    rd_b     [BANKS];

    logic accept, serving, last;

    assign req_ready = (st == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign serving   = (st == ST_SERVE);

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        scp_bank_pick #(.BANK_ID(b)) u_pick (
            .clk     (clk),
            .rst     (rst),
            .enable  (serving),
            .pending (pend_q),
            .addr    (addr_q),
            .wdata   (wd_q),
            .served  (served_b[b]),
            .hit_any (any_b[b]),
            .row     (row_b[b]),
            .wsel    (wsel_b[b])
        );
        scp_bank u_mem (
            .clk   (clk),
            .wr_en (serving && hdr_q.write && any_b[b]),
            .row   (row_b[b]),
            .wdata (wsel_b[b]),
            .rdata (rd_b[b])
        );
    end

    always_comb begin
        served_all = '0;
        for (int b = 0; b < BANKS; b++) served_all |= served_b[b];
    end

    assign pend_nxt = pend_q & ~served_all;
    assign last     = serving && (pend_nxt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            hdr_q   <= '0;
            pend_q  <= '0;
            rdv_q   <= '0;
            svc_cnt <= '0;
            for (int l = 0; l < LANES; l++) begin
                addr_q[l] <= '0;
                wd_q[l]   <= '0;
                res_q[l]  <= '0;
            end
        end else begin
            rdv_q <= '0;
            if (accept) begin
                st           <= ST_SERVE;
                hdr_q.write  <= req_write;
                hdr_q.active <= req_active;
                pend_q       <= req_active;
                svc_cnt      <= '0;
                for (int l = 0; l < LANES; l++) begin
                    addr_q[l] <= req_addr[l*AW +: AW];
                    wd_q[l]   <= req_wdata[l*DW +: DW];
                end
            end else if (serving) begin
                pend_q  <= pend_nxt;
                svc_cnt <= svc_cnt + 1'b1;
                for (int l = 0; l < LANES; l++) begin
                    if (served_all[l] && !hdr_q.write)
                        res_q[l] <= rd_b[bank_of(addr_q[l])];
                end
                if (last) begin
                    st    <= ST_IDLE;
                    rdv_q <= hdr_q.write ? '0 : hdr_q.active;
                end
            end
        end
    end

    assign rd_valid = rdv_q;
    for (genvar l = 0; l < LANES; l++) begin : g_out
        assign rd_data[l*DW +: DW] = res_q[l];
    end

    // R7: ready drops right after a request is taken
    a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        accept |=> !req_ready);
    // R8: results appear only right after a service cycle
    a_r8_valid_after_service: assert property (@(posedge clk) disable iff (rst)
        (rd_valid != '0) |-> ($past(serving) && req_ready));
    // R9: no valid for a lane that was not active
    a_r9_valid_subset: assert property (@(posedge clk) disable iff (rst)
        (rd_valid & ~hdr_q.active) == '0);
    // R5: every service cycle retires at least one pending lane
    a_r5_progress: assert property (@(posedge clk) disable iff (rst)
        (serving && pend_q != '0) |=> ($countones(pend_q) < $countones($past(pend_q))));
    // R5: service never outlasts one cycle per lane
    a_r5_bound: assert property (@(posedge clk) disable iff (rst)
        last |-> (svc_cnt < SVC_LIM));
endmodule

// File: tb/scp_banked_top_test.sv
`timescale 1ns/1ps
module scp_banked_top_test;
    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [15:0]   req_active = '0;
    logic [191:0]  req_addr = '0;
    logic [511:0]  req_wdata = '0;
    logic          req_ready;
    logic [15:0]   rd_valid;
    logic [511:0]  rd_data;

    always #2.5 clk = ~clk;

    scp_banked_top uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_active(req_active), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    int checks = 0;
    int errors = 0;
    logic [31:0] model [4096];
    logic [11:0] ta [16];
    logic [31:0] td [16];
    int unsigned seed = 32'h1234_5678;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint actv, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, actv, expv);
        end
    endtask

    function automatic logic [31:0] hashw(input int a);
        return 32'hA5A5_0000 ^ (32'(a) * 32'h9E37_79B1);
    endfunction

    task automatic run_req(input bit wr, input logic [15:0] act, input string tag);
        int exp_cyc = 0;
        int cyc = 0;
        logic [31:0] exp_rd [16];
        bit data_ok = 1;
        for (int b = 0; b < 16; b++) begin
            int cnt = 0;
            for (int l = 0; l < 16; l++) begin
                bit dup = 0;
                if (!act[l] || (ta[l] % 16) != b) continue;
                for (int j = 0; j < l; j++)
                    if (act[j] && ta[j] == ta[l]) dup = 1;
                if (!dup) cnt++;
            end
            if (cnt > exp_cyc) exp_cyc = cnt;
        end
        if (exp_cyc == 0) exp_cyc = 1;
        for (int l = 0; l < 16; l++) exp_rd[l] = model[ta[l]];
        if (wr) for (int l = 0; l < 16; l++) if (act[l]) model[ta[l]] = td[l];

        @(negedge clk);
        check(req_ready === 1'b1, "R7", "ready before request", req_ready, 1);
        req_valid  = 1'b1;
        req_write  = wr;
        req_active = act;
        for (int l = 0; l < 16; l++) begin
            req_addr[l*12 +: 12]  = ta[l];
            req_wdata[l*32 +: 32] = td[l];
        end
        @(negedge clk);
        req_valid = 1'b0;
        while (req_ready !== 1'b1 && cyc < 40) begin
            if (rd_valid !== 16'h0) begin
                errors++; checks++;
                $display("FAIL R8 valid while busy: actual %0h expected 0", rd_valid);
            end
            cyc++;
            @(negedge clk);
        end
        check(cyc == exp_cyc, tag, "service cycles", cyc, exp_cyc);
        check(rd_valid === (wr ? 16'h0 : act), "R8", "rd_valid", rd_valid, wr ? 16'h0 : act);
        if (!wr) begin
            for (int l = 0; l < 16; l++) begin
                if (act[l] && rd_data[l*32 +: 32] !== exp_rd[l]) begin
                    data_ok = 0;
                    $display("FAIL %s lane %0d data: actual %0h expected %0h",
                             tag, l, rd_data[l*32 +: 32], exp_rd[l]);
                end
            end
            checks++;
            if (!data_ok) errors++;
        end
        @(negedge clk);
        check(rd_valid === 16'h0, "R8", "valid is a single pulse", rd_valid, 0);
    endtask

    initial begin
        #(100000 * 5);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready === 1'b1, "R1", "ready after reset", req_ready, 1);
        check(rd_valid === 16'h0, "R1", "rd_valid after reset", rd_valid, 0);

        // R2 / R3: fill every word, one row per request, lanes on distinct banks
        for (int k = 0; k < 256; k++) begin
            for (int l = 0; l < 16; l++) begin ta[l] = 12'(k*16 + l); td[l] = hashw(k*16 + l); end
            run_req(1, 16'hFFFF, "R3");
        end
        for (int l = 0; l < 16; l++) ta[l] = 12'(l);
        run_req(0, 16'hFFFF, "R2");
        for (int l = 0; l < 16; l++) ta[l] = 12'(4080 + l);
        run_req(0, 16'hFFFF, "R2");
        for (int l = 0; l < 16; l++) ta[l] = 12'(100 + ((l * 5) % 16));
        run_req(0, 16'hFFFF, "R3");

        // R5: stride 2 gives two per bank, stride 16 gives sixteen on one bank
        for (int l = 0; l < 16; l++) ta[l] = 12'(100 + 2*l);
        run_req(0, 16'hFFFF, "R5");
        for (int l = 0; l < 16; l++) begin ta[l] = 12'(16*l + 3); td[l] = 32'hC0DE_0000 + 32'(l); end
        run_req(1, 16'hFFFF, "R5");
        run_req(0, 16'hFFFF, "R5");

        // R4: broadcast of a single word
        for (int l = 0; l < 16; l++) ta[l] = 12'd105;
        run_req(0, 16'hFFFF, "R4");
        // R4: mixed broadcast groups and a conflict
        for (int l = 0; l < 16; l++) ta[l] = 12'(l < 4 ? 400 : (l < 6 ? 416 : (l == 6 ? 432 : 400 + l)));
        run_req(0, 16'hFFFF, "R4");

        // R6: all lanes store to one word, then read it back
        for (int l = 0; l < 16; l++) begin ta[l] = 12'd200; td[l] = 32'hBEEF_0000 + 32'(l); end
        run_req(1, 16'hFFFF, "R6");
        run_req(0, 16'h0001, "R6");
        for (int l = 0; l < 16; l++) begin ta[l] = 12'd201; td[l] = 32'hFACE_0000 + 32'(l); end
        run_req(1, 16'h00FF, "R6");
        run_req(0, 16'h0001, "R6");

        // R9: inactive lanes carry conflicting addresses and data
        for (int l = 0; l < 16; l++) begin ta[l] = 12'(300 + 16*l); td[l] = 32'hDEAD_0000 + 32'(l); end
        run_req(1, 16'h0001, "R9");
        for (int l = 0; l < 16; l++) ta[l] = 12'(300 + 16*l);
        run_req(0, 16'hFFFF, "R9");
        run_req(0, 16'h0000, "R5");

        // R10: back-to-back mixed traffic over a small region
        for (int n = 0; n < 80; n++) begin
            logic [15:0] act;
            bit wr;
            seed = seed * 1664525 + 1013904223;
            act = seed[31:16];
            wr  = seed[3];
            for (int l = 0; l < 16; l++) begin
                seed = seed * 1664525 + 1013904223;
                ta[l] = 12'(seed[23:18]);
                td[l] = seed;
            end
            run_req(wr, act, "R10");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule